// File: doc/BRIEF.md
# Single-Precision Result Clamp and Status Register

This block sits beside the arithmetic datapath of a single-precision floating-point unit that has no infinities and no denormals. It does two jobs on the way in. Any operand whose exponent field is zero becomes a signed zero. Any operand whose exponent field is all ones becomes the signed largest finite value. The conditioned operands go to the datapath.

On the way out, the block takes the datapath's raw result and checks it against the operation class. It saturates an infinite result to the signed largest finite value and flushes a denormal result to signed zero. It replaces the result of a division by a zero divisor. It also keeps a 32-bit control/status word with cause bits, sticky bits and a compare condition bit.

Each valid operation updates the status word on one clock edge. Software can also load the whole word through a dedicated write port.

Top module: `fpu_clamp_status`

## Requirements
- R1: The outputs `pre_a` and `pre_b` condition `src_a` and `src_b` as follows. An exponent field [30:23] of zero gives the sign bit alone. An exponent field of 0xFF gives sign | 0x7F7FFFFF. Any other value passes unchanged.
- R2: In class ARITH (op_class=1), a raw result whose bits [30:0] equal 0x7F800000 is an overflow. The output becomes sign | 0x7F7FFFFF, and the operation sets status bits 15 and 4.
- R3: In class ARITH, a raw result with a zero exponent field and a nonzero fraction is an underflow. The output becomes the sign bit alone, and the operation sets status bits 14 and 3. The overflow test is made first, and when it fires the underflow flags are not set.
- R4: In class ARITH, any other raw result passes unchanged and sets no status bit. Class PASS (op_class=0, and the unused code 7) passes the raw result and leaves the status word unchanged.
- R5: In class DIVQ (op_class=2, used for divide and reciprocal square root), when the divisor `src_b` has a nonzero exponent, the result is saturated or flushed as in R2 and R3. No status bit is set.
- R6: In class DIVQ, when `src_b` has a zero exponent field, the result is (src_a[31] XOR src_b[31]) | 0x7F7FFFFF. If `src_a` also has a zero exponent field, status bits 17 and 6 are set; otherwise bits 16 and 5 are set.
- R7: Class SIGNOP (op_class=3, used for abs, negate, min and max) passes the raw result and clears status bits 15 and 14.
- R8: Class SQRT (op_class=4) takes its input in `src_a`. An input with a zero exponent field gives +0. A negative input sets status bits 17 and 6, and the output is the raw result with bit 31 cleared. Every SQRT operation clears status bit 16.
- R9: Class CMP (op_class=5) writes `cmp_true` into status bit 23. Class CFALSE (op_class=6) clears bit 23.
- R10: On a valid operation, every bit set in `clr_mask` is cleared on the same edge as the class's own updates. When the same bit is both cleared and set, the set wins.
- R11: When `sw_we` is high, the status word loads `sw_data` on the next edge, even if an operation is valid in the same cycle.
- R12: A synchronous reset sets the status word to zero. With neither `op_valid` nor `sw_we` high, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An operation completes this cycle |
| op_class | input | 3 | Operation class code |
| src_a | input | 32 | First operand (dividend, or square-root input) |
| src_b | input | 32 | Second operand (divisor) |
| raw_res | input | 32 | Unconditioned result from the datapath |
| clr_mask | input | 32 | Status bits to clear with this operation |
| cmp_true | input | 1 | Outcome of a compare |
| sw_we | input | 1 | Software write strobe for the status word |
| sw_data | input | 32 | Software write value |
| pre_a | output | 32 | Conditioned first operand |
| pre_b | output | 32 | Conditioned second operand |
| res_out | output | 32 | Corrected result |
| status | output | 32 | Control/status word |

## Verification
Two kinds of update can land on the same edge. The first is a software load of the status word together with an operation-driven update. The bench drives `sw_we` in the same cycle as an overflowing ARITH operation and expects only the software value afterwards.

The second is a class operation together with a clear mask. The bench issues operations whose `clr_mask` covers the very bits the operation sets or clears, and checks that the set survives. A running model of the status word, kept in the bench, judges every edge of the exponent sweeps.

// File: rtl/fpu_clamp_status.sv
module fpu_clamp_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [2:0]   op_class,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [W-1:0] raw_res,
  input  logic [W-1:0] clr_mask,
  input  logic         cmp_true,
  input  logic         sw_we,
  input  logic [W-1:0] sw_data,
  output logic [W-1:0] pre_a,
  output logic [W-1:0] pre_b,
  output logic [W-1:0] res_out,
  output logic [W-1:0] status
);

  localparam int EXP_HI = W - 2;
  localparam int EXP_LO = W - 9;
  localparam logic [W-2:0] MAXF = 31'h7F7FFFFF;
  localparam logic [W-2:0] INFM = 31'h7F800000;

  localparam int B_COND = 23;
  localparam int B_INV  = 17;
  localparam int B_DIV  = 16;
  localparam int B_OVF  = 15;
  localparam int B_UNF  = 14;
  localparam int S_INV  = 6;
  localparam int S_DIV  = 5;
  localparam int S_OVF  = 4;
  localparam int S_UNF  = 3;

  typedef enum logic [2:0] {
    C_PASS   = 3'd0,
    C_ARITH  = 3'd1,
    C_DIVQ   = 3'd2,
    C_SIGNOP = 3'd3,
    C_SQRT   = 3'd4,
    C_CMP    = 3'd5,
    C_CFALSE = 3'd6
  } op_class_t;

  function automatic logic [W-1:0] cond_in(input logic [W-1:0] x);
    if (x[EXP_HI:EXP_LO] == '0)      return {x[W-1], {(W-1){1'b0}}};
    else if (&x[EXP_HI:EXP_LO])      return {x[W-1], MAXF};
    else                             return x;
  endfunction

  assign pre_a = cond_in(src_a);
  assign pre_b = cond_in(src_b);

  wire r_sign = raw_res[W-1];
  wire r_ovf  = raw_res[W-2:0] == INFM;
  wire r_unf  = !r_ovf && (raw_res[EXP_HI:EXP_LO] == '0) && (raw_res[EXP_LO-1:0] != '0);
  wire a_zero = src_a[EXP_HI:EXP_LO] == '0;
  wire b_zero = src_b[EXP_HI:EXP_LO] == '0;

  wire [W-1:0] clamped = r_ovf ? {r_sign, MAXF} :
                         r_unf ? {r_sign, {(W-1){1'b0}}} : raw_res;

  op_class_t cls;
  assign cls = op_class_t'(op_class);

  logic [W-1:0] set_bits, clr_bits;

  always_comb begin
    res_out  = raw_res;
    set_bits = '0;
    clr_bits = '0;
    case (cls)
      C_ARITH: begin
        res_out = clamped;
        if (r_ovf) begin
          set_bits[B_OVF] = 1'b1;
          set_bits[S_OVF] = 1'b1;
        end else if (r_unf) begin
          set_bits[B_UNF] = 1'b1;
          set_bits[S_UNF] = 1'b1;
        end
      end
      C_DIVQ: begin
        if (b_zero) begin
          res_out = {src_a[W-1] ^ src_b[W-1], MAXF};
          if (a_zero) begin
            set_bits[B_INV] = 1'b1;
            set_bits[S_INV] = 1'b1;
          end else begin
            set_bits[B_DIV] = 1'b1;
            set_bits[S_DIV] = 1'b1;
          end
        end else begin
          res_out = clamped;
        end
      end
      C_SIGNOP: begin
        clr_bits[B_OVF] = 1'b1;
        clr_bits[B_UNF] = 1'b1;
      end
      C_SQRT: begin
        clr_bits[B_DIV] = 1'b1;
        if (a_zero) begin
          res_out = '0;
        end else begin
          res_out = {1'b0, raw_res[W-2:0]};
          if (src_a[W-1]) begin
            set_bits[B_INV] = 1'b1;
            set_bits[S_INV] = 1'b1;
          end
        end
      end
      C_CMP: begin
        if (cmp_true) set_bits[B_COND] = 1'b1;
        else          clr_bits[B_COND] = 1'b1;
      end
      C_CFALSE: clr_bits[B_COND] = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           status <= '0;
    else if (sw_we)    status <= sw_data;
    else if (op_valid) status <= (status & ~(clr_bits | clr_mask)) | set_bits;
  end

  p_sw_write_r11: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> status == $past(sw_data));

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && !op_valid) |=> $stable(status));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !sw_we && op_class == 3'd1 && raw_res[W-2:0] == INFM)
      |=> (status[B_OVF] && status[S_OVF]));

  p_ovf_result_r2: assert property (@(posedge clk) disable iff (rst)
    (op_class == 3'd1 && raw_res[W-2:0] == INFM) |-> res_out[W-2:0] == MAXF);

  p_div_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !sw_we && op_class == 3'd2 && src_b[EXP_HI:EXP_LO] == '0)
      |=> (status[B_INV] || status[B_DIV]));

  p_div_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !sw_we && op_class == 3'd2 && src_b[EXP_HI:EXP_LO] != '0 && clr_mask == '0)
      |=> $stable(status));

  p_cmp_r9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !sw_we && op_class == 3'd5) |=> status[B_COND] == $past(cmp_true));

  p_pre_range_r1: assert property (@(posedge clk) disable iff (rst)
    pre_a[EXP_HI:EXP_LO] != '1 && pre_b[EXP_HI:EXP_LO] != '1);

endmodule

// File: tb/test_fpu_clamp_status.sv
module test_fpu_clamp_status;
  logic        clk = 0;
  logic        rst = 1;
  logic        op_valid = 0;
  logic [2:0]  op_class = 0;
  logic [31:0] src_a = 0, src_b = 0, raw_res = 0, clr_mask = 0, sw_data = 0;
  logic        cmp_true = 0, sw_we = 0;
  logic [31:0] pre_a, pre_b, res_out, status;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_st = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fpu_clamp_status i_fpu_clamp_status (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class),
    .src_a(src_a), .src_b(src_b), .raw_res(raw_res), .clr_mask(clr_mask),
    .cmp_true(cmp_true), .sw_we(sw_we), .sw_data(sw_data),
    .pre_a(pre_a), .pre_b(pre_b), .res_out(res_out), .status(status));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] m_pre(input logic [31:0] x);
    if (x[30:23] == 8'h00) return x & 32'h8000_0000;
    if (x[30:23] == 8'hFF) return (x & 32'h8000_0000) | 32'h7F7F_FFFF;
    return x;
  endfunction

  function automatic bit is_ovf(input logic [31:0] r);
    return (r & 32'h7FFF_FFFF) == 32'h7F80_0000;
  endfunction

  function automatic bit is_unf(input logic [31:0] r);
    return r[30:23] == 0 && r[22:0] != 0;
  endfunction

  function automatic logic [31:0] m_res(input int c, input logic [31:0] a, b, r);
    logic [31:0] cl;
    cl = is_ovf(r) ? ((r & 32'h8000_0000) | 32'h7F7F_FFFF) :
         is_unf(r) ? (r & 32'h8000_0000) : r;
    case (c)
      1: return cl;
      2: return (b[30:23] == 0) ? (((a ^ b) & 32'h8000_0000) | 32'h7F7F_FFFF) : cl;
      4: return (a[30:23] == 0) ? 32'h0 : (r & 32'h7FFF_FFFF);
      default: return r;
    endcase
  endfunction

  function automatic logic [31:0] m_next(input logic [31:0] st, input int c,
      input logic [31:0] a, b, r, cm, input bit ct);
    logic [31:0] s = 0, k = 0;
    case (c)
      1: if (is_ovf(r)) s = (1 << 15) | (1 << 4);
         else if (is_unf(r)) s = (1 << 14) | (1 << 3);
      2: if (b[30:23] == 0) s = (a[30:23] == 0) ? ((1 << 17) | (1 << 6)) : ((1 << 16) | (1 << 5));
      3: k = (1 << 15) | (1 << 14);
      4: begin k = 1 << 16; if (a[30:23] != 0 && a[31]) s = (1 << 17) | (1 << 6); end
      5: if (ct) s = 1 << 23; else k = 1 << 23;
      6: k = 1 << 23;
      default: ;
    endcase
    return (st & ~(k | cm)) | s;
  endfunction

  task automatic do_op(input string tag, input int c, input logic [31:0] a, b, r, cm,
      input bit ct, input bit we, input logic [31:0] wd);
    @(negedge clk);
    op_valid = 1; op_class = c[2:0]; src_a = a; src_b = b; raw_res = r;
    clr_mask = cm; cmp_true = ct; sw_we = we; sw_data = wd;
    #2;
    chk({tag, " result"}, res_out, m_res(c, a, b, r));
    exp_st = we ? wd : m_next(exp_st, c, a, b, r, cm, ct);
    @(negedge clk);
    op_valid = 0; sw_we = 0; clr_mask = 0;
    chk({tag, " status"}, status, exp_st);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] pat [4];
    pat[0] = 32'h0000_0000; pat[1] = 32'h0000_0001;
    pat[2] = 32'h8040_0000; pat[3] = 32'h807F_FFFF;

    sw_we = 1; sw_data = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    sw_we = 0;
    chk("R12 reset", status, 32'h0);
    rst = 0;
    exp_st = 0;

    @(negedge clk); @(negedge clk);
    chk("R12 idle hold", status, 32'h0);

    for (int e = 0; e < 256; e++)
      for (int p = 0; p < 4; p++) begin
        logic [31:0] x, y;
        x = pat[p] | (32'(e) << 23);
        y = pat[3 - p] | (32'(255 - e) << 23);
        src_a = x; src_b = y;
        #1;
        chk("R1 pre_a", pre_a, m_pre(x));
        chk("R1 pre_b", pre_b, m_pre(y));
      end

    for (int e = 0; e < 256; e++)
      for (int p = 0; p < 4; p++) begin
        logic [31:0] r;
        string t;
        r = pat[p] | (32'(e) << 23);
        t = (e == 255 && pat[p][22:0] == 0) ? "R2 arith" : (e == 0 && pat[p][22:0] != 0) ? "R3 arith" : "R4 arith";
        do_op(t, 1, 32'h3F80_0000, 32'h4000_0000, r, (e % 16 == 0) ? 32'h0000_C018 : 32'h0, 0, 0, 0);
      end

    do_op("R4 pass", 0, 32'h1, 32'h2, 32'h7F80_0000, 0, 0, 0, 0);
    do_op("R4 class7", 7, 32'h1, 32'h2, 32'h0000_0005, 0, 0, 0, 0);

    do_op("R10 clear all", 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, 0);
    for (int e = 0; e < 256; e += 5)
      for (int p = 0; p < 4; p++)
        do_op("R5 divq", 2, 32'h4000_0000, 32'h3F80_0000 | (p << 31), pat[p] | (32'(e) << 23), 0, 0, 0, 0);
    do_op("R5 divq ovf", 2, 32'h4000_0000, 32'h3F80_0000, 32'hFF80_0000, 0, 0, 0, 0);

    do_op("R6 div0 nz", 2, 32'h4000_0000, 32'h8000_0003, 32'h1234_5678, 0, 0, 0, 0);
    do_op("R10 clr", 0, 0, 0, 0, 32'h0003_0060, 0, 0, 0);
    do_op("R6 div0 zz", 2, 32'h8000_0010, 32'h0000_0000, 32'h1234_5678, 0, 0, 0, 0);
    do_op("R6 div0 pos", 2, 32'h0080_0000, 32'h0000_0000, 32'h0, 0, 0, 0, 0);

    do_op("R2 set ovf", 1, 0, 0, 32'h7F80_0000, 0, 0, 0, 0);
    do_op("R3 set unf", 1, 0, 0, 32'h0000_0100, 0, 0, 0, 0);
    do_op("R7 signop", 3, 32'hBF80_0000, 0, 32'h3F80_0000, 0, 0, 0, 0);

    do_op("R8 sqrt zero", 4, 32'h8000_0001, 0, 32'h4000_0000, 0, 0, 0, 0);
    do_op("R8 sqrt neg", 4, 32'hC080_0000, 0, 32'hC000_0000, 0, 0, 0, 0);
    do_op("R8 sqrt pos", 4, 32'h4080_0000, 0, 32'h4000_0000, 0, 0, 0, 0);

    do_op("R9 cmp true", 5, 0, 0, 0, 0, 1, 0, 0);
    do_op("R9 cmp false", 5, 0, 0, 0, 0, 0, 0, 0);
    do_op("R9 cmp true2", 5, 0, 0, 0, 0, 1, 0, 0);
    do_op("R9 cfalse", 6, 0, 0, 0, 0, 1, 0, 0);

    do_op("R10 set wins", 1, 0, 0, 32'hFF80_0000, 32'h0000_8010, 0, 0, 0);
    do_op("R10 set wins cmp", 5, 0, 0, 0, 32'h0080_0000, 1, 0, 0);

    do_op("R11 sw vs op", 1, 0, 0, 32'h7F80_0000, 0, 0, 1, 32'h0000_0A5A);
    do_op("R11 sw alone", 0, 0, 0, 0, 0, 0, 1, 32'hDEAD_BEEF);
    op_valid = 0;
    @(negedge clk); @(negedge clk);
    chk("R12 hold after write", status, 32'hDEAD_BEEF);

    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R12 reset again", status, 32'h0);

    done = 1;
    finish_run();
  end
endmodule